// File: doc/BRIEF.md
# One-Time-Programmable Fuse Controller

This block sits between a host register bus and a small one-time-programmable fuse array. The host loads timing fields, a word address, program data and a command. The block then runs a timed setup, head-relax, strobe and tail-relax sequence on the array. A read leaves the fuse word in a result register. A program ORs data into the addressed word. A reload copies every fuse word into a bank of shadow registers without resetting the block.

While a sequence runs, a busy flag is high. A sticky error flag records every rejected command. It is cleared only through a separate clear register. A program command picks its protection per word. Write-once mode refuses a word that has already been programmed. Accumulate mode ORs new bits into the word on each program. A lock flag on the command freezes the word after the program completes.

The sequencer has six states. It leaves IDLE on an accepted command. A reload goes to RELOAD, and a read or program goes to SETUP. SETUP leads to RLX_HEAD, then STROBE, then RLX_TAIL, and each transition happens when the state's down-counter reaches zero. RLX_TAIL returns to IDLE. RELOAD returns to IDLE after the last word.

Register map (`bus_addr`):
- 0: control. A write starts a command. Bits [1:0] hold the command: 1 read, 2 program, 3 reload, 0 none. Bit 2 selects write-once mode for a program. Bit 3 locks the word after the program. A read returns busy in bit 0 and error in bit 1.
- 1: clear. Writing 1 to bit 1 clears the error flag.
- 2: timing, laid out as {read strobe, program strobe, relax, wait}, 6 bits each from bit 0 up.
- 3: word address.
- 4: program data.
- 5: read result.
- 6: shadow word at the current address.
- 7: lock bits, one per word.

Top module: `fuse_ctl`

## Requirements
- R1: After reset, busy and error read 0, the timing register reads 0x00189042 (wait 2, relax 1, program strobe 9, read strobe 6), and the shadow words and lock bits read 0.
- R2: A read keeps busy high for (WAIT+1)+(RSTROBE+1) cycles. Of these, fuse_strobe is high for RSTROBE+1 cycles and fuse_active for (RSTROBE+1)-2(RELAX+1) cycles. One relax period stands on each side of the active window.
- R3: A program keeps busy high for (RELAX+1)+(PSTROBE+1) cycles, with fuse_active high for (PSTROBE+1)-2(RELAX+1) cycles.
- R4: A read or program whose active width would be zero or negative is rejected. It sets error, and neither busy nor fuse_strobe ever rises.
- R5: A command written while busy is ignored and sets error. The running operation and the fuse contents are unaffected.
- R6: Error is sticky. Writing the control register does not clear it, and neither does writing the clear register with bit 1 at 0. Writing the clear register with bit 1 at 1 clears it.
- R7: A program to a locked word is rejected with error, and the word keeps its value.
- R8: In write-once mode (control bit 2 = 1), a program to a word that was already programmed is rejected with error.
- R9: In accumulate mode (control bit 2 = 0), each program ORs its data into the word.
- R10: A reload holds busy for one cycle per word and copies every fuse word into the shadow bank. A program alone leaves the shadow word unchanged.
- R11: Program data reaches the fuse array only while fuse_active is high.
- R12: A completed read places the addressed fuse word in the read result register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register index |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational on bus_addr |
| fuse_strobe | output | 1 | Whole strobe window, including both relax periods |
| fuse_active | output | 1 | Active part of the strobe window |

## Verification
Some properties are checked on every cycle. The active window is always framed by strobe on both sides. Error is sticky until the clear write, and a command issued while busy always raises error. The array changes only when its program enable is high. No active program cycle touches a locked word, or a write-once word that was already programmed. Only the bench scenarios can show the rest: the exact cycle counts of each operation, the accumulated values, the reload order against the shadow bank, and that rejected commands leave the array's contents as they were.

// File: rtl/fuse_pkg.sv
package fuse_pkg;

    typedef enum logic [1:0] {
        OP_NONE   = 2'd0,
        OP_READ   = 2'd1,
        OP_PROG   = 2'd2,
        OP_RELOAD = 2'd3
    } fuse_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_RLX_HEAD,
        ST_STROBE,
        ST_RLX_TAIL,
        ST_RELOAD
    } seq_state_e;

    localparam int REG_CTRL   = 0;
    localparam int REG_CLR    = 1;
    localparam int REG_TIME   = 2;
    localparam int REG_ADDR   = 3;
    localparam int REG_WDATA  = 4;
    localparam int REG_RDVAL  = 5;
    localparam int REG_SHADOW = 6;
    localparam int REG_LOCK   = 7;

endpackage

// File: rtl/fuse_array.sv
module fuse_array #(
    parameter int NW = 8,
    parameter int DW = 32,
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pgm_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] q
);

    logic [NW-1:0][DW-1:0] cells;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cells <= '0;
        end else if (pgm_en) begin
            cells[addr] <= cells[addr] | wdata;
        end
    end

    assign q = cells[addr];

    // R11
    cells_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pgm_en |=> $stable(cells));

endmodule

// File: rtl/fuse_seq.sv
module fuse_seq
    import fuse_pkg::*;
#(
    parameter int TW = 6,
    parameter int NW = 8,
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  fuse_op_e      op_in,
    input  logic [TW-1:0] setup_len,
    input  logic [TW-1:0] relax_len,
    input  logic [TW-1:0] act_m1,
    output fuse_op_e      op_cur,
    output logic          busy,
    output logic          strobe,
    output logic          active,
    output logic          capture,
    output logic          reload_we,
    output logic [AW-1:0] reload_idx
);

    localparam int CW = (TW > AW) ? TW : AW;

    seq_state_e    state, state_n;
    logic [CW-1:0] cnt, cnt_n;
    fuse_op_e      op_q, op_n;
    logic [TW-1:0] relax_l, act_l;

    // next state and counter
    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        op_n    = op_q;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    op_n = op_in;
                    if (op_in == OP_RELOAD) begin
                        state_n = ST_RELOAD;
                        cnt_n   = '0;
                    end else begin
                        state_n = ST_SETUP;
                        cnt_n   = CW'(setup_len);
                    end
                end
            end
            ST_SETUP: begin
                if (cnt == '0) begin
                    state_n = ST_RLX_HEAD;
                    cnt_n   = CW'(relax_l);
                end else begin
                    cnt_n = cnt - 1'b1;
                end
            end
            ST_RLX_HEAD: begin
                if (cnt == '0) begin
                    state_n = ST_STROBE;
                    cnt_n   = CW'(act_l);
                end else begin
                    cnt_n = cnt - 1'b1;
                end
            end
            ST_STROBE: begin
                if (cnt == '0) begin
                    state_n = ST_RLX_TAIL;
                    cnt_n   = CW'(relax_l);
                end else begin
                    cnt_n = cnt - 1'b1;
                end
            end
            ST_RLX_TAIL: begin
                if (cnt == '0) begin
                    state_n = ST_IDLE;
                end else begin
                    cnt_n = cnt - 1'b1;
                end
            end
            ST_RELOAD: begin
                if (cnt == CW'(NW - 1)) begin
                    state_n = ST_IDLE;
                end else begin
                    cnt_n = cnt + 1'b1;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            op_q    <= OP_NONE;
            relax_l <= '0;
            act_l   <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
            op_q  <= op_n;
            if (state == ST_IDLE && start) begin
                relax_l <= relax_len;
                act_l   <= act_m1;
            end
        end
    end

    // outputs
    always_comb begin
        busy       = (state != ST_IDLE);
        strobe     = (state == ST_RLX_HEAD) || (state == ST_STROBE) || (state == ST_RLX_TAIL);
        active     = (state == ST_STROBE);
        capture    = (state == ST_STROBE) && (cnt == '0);
        reload_we  = (state == ST_RELOAD);
        reload_idx = cnt[AW-1:0];
        op_cur     = op_q;
    end

    // R2
    head_relax_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> $past(strobe));

    // R2
    tail_relax_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active) |-> strobe);

endmodule

// File: rtl/fuse_ctl.sv
module fuse_ctl
    import fuse_pkg::*;
#(
    parameter int NW        = 8,
    parameter int DW        = 32,
    parameter int TW        = 6,
    parameter int RAW       = 3,
    parameter int WAIT_RST  = 2,
    parameter int RELAX_RST = 1,
    parameter int PSTR_RST  = 9,
    parameter int RSTR_RST  = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bus_we,
    input  logic [RAW-1:0] bus_addr,
    input  logic [DW-1:0]  bus_wdata,
    output logic [DW-1:0]  bus_rdata,
    output logic           fuse_strobe,
    output logic           fuse_active
);

    localparam int AW = $clog2(NW);
    localparam int SW = TW + 3;

    logic [TW-1:0] wait_q, relax_q, pstr_q, rstr_q;
    logic [AW-1:0] addr_q, addr_l;
    logic [DW-1:0] wdata_q, data_l, rdval_q;
    logic          err_q, ecc_l, lock_l;
    logic [NW-1:0] lock_q, pgmd_q;
    logic [NW-1:0][DW-1:0] shadow_q;

    fuse_op_e      cmd_op, op_cur;
    logic          cmd_wr, clr_hit, reject, start, pulse_ok;
    logic          busy, capture, reload_we, pgm_en;
    logic [AW-1:0] reload_idx, arr_addr;
    logic [DW-1:0] arr_q;
    logic [TW-1:0] strobe_sel, setup_sel, act_m1;
    logic signed [SW-1:0] act_s;

    // command decode and acceptance
    always_comb begin
        cmd_op     = fuse_op_e'(bus_wdata[1:0]);
        cmd_wr     = bus_we && (bus_addr == RAW'(REG_CTRL)) && (cmd_op != OP_NONE);
        clr_hit    = bus_we && (bus_addr == RAW'(REG_CLR)) && bus_wdata[1];
        strobe_sel = (cmd_op == OP_PROG) ? pstr_q : rstr_q;
        setup_sel  = (cmd_op == OP_PROG) ? relax_q : wait_q;
        act_s      = $signed({3'b000, strobe_sel}) - $signed({2'b00, relax_q, 1'b0})
                     - SW'(signed'(1));
        pulse_ok   = (act_s > 0);
        act_m1     = TW'(act_s - SW'(signed'(1)));
        reject     = busy
                  || ((cmd_op != OP_RELOAD) && !pulse_ok)
                  || ((cmd_op == OP_PROG) && lock_q[addr_q])
                  || ((cmd_op == OP_PROG) && bus_wdata[2] && pgmd_q[addr_q]);
        start      = cmd_wr && !reject;
    end

    fuse_seq #(.TW(TW), .NW(NW), .AW(AW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .op_in      (cmd_op),
        .setup_len  (setup_sel),
        .relax_len  (relax_q),
        .act_m1     (act_m1),
        .op_cur     (op_cur),
        .busy       (busy),
        .strobe     (fuse_strobe),
        .active     (fuse_active),
        .capture    (capture),
        .reload_we  (reload_we),
        .reload_idx (reload_idx)
    );

    assign pgm_en   = fuse_active && (op_cur == OP_PROG);
    assign arr_addr = reload_we ? reload_idx : addr_l;

    fuse_array #(.NW(NW), .DW(DW), .AW(AW)) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .pgm_en(pgm_en),
        .addr  (arr_addr),
        .wdata (data_l),
        .q     (arr_q)
    );

    // register file
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wait_q   <= TW'(WAIT_RST);
            relax_q  <= TW'(RELAX_RST);
            pstr_q   <= TW'(PSTR_RST);
            rstr_q   <= TW'(RSTR_RST);
            addr_q   <= '0;
            wdata_q  <= '0;
            rdval_q  <= '0;
            err_q    <= 1'b0;
            lock_q   <= '0;
            pgmd_q   <= '0;
            shadow_q <= '0;
            addr_l   <= '0;
            data_l   <= '0;
            ecc_l    <= 1'b0;
            lock_l   <= 1'b0;
        end else begin
            if (bus_we && bus_addr == RAW'(REG_TIME))
                {rstr_q, pstr_q, relax_q, wait_q} <= bus_wdata[4*TW-1:0];
            if (bus_we && bus_addr == RAW'(REG_ADDR))
                addr_q <= bus_wdata[AW-1:0];
            if (bus_we && bus_addr == RAW'(REG_WDATA))
                wdata_q <= bus_wdata;
            if (cmd_wr && reject)
                err_q <= 1'b1;
            else if (clr_hit)
                err_q <= 1'b0;
            if (start) begin
                addr_l <= addr_q;
                data_l <= wdata_q;
                ecc_l  <= bus_wdata[2];
                lock_l <= bus_wdata[3];
            end
            if (capture && op_cur == OP_READ)
                rdval_q <= arr_q;
            if (capture && op_cur == OP_PROG) begin
                pgmd_q[addr_l] <= 1'b1;
                if (lock_l)
                    lock_q[addr_l] <= 1'b1;
            end
            if (reload_we)
                shadow_q[reload_idx] <= arr_q;
        end
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            RAW'(REG_CTRL):   bus_rdata[1:0] = {err_q, busy};
            RAW'(REG_TIME):   bus_rdata[4*TW-1:0] = {rstr_q, pstr_q, relax_q, wait_q};
            RAW'(REG_ADDR):   bus_rdata[AW-1:0] = addr_q;
            RAW'(REG_WDATA):  bus_rdata = wdata_q;
            RAW'(REG_RDVAL):  bus_rdata = rdval_q;
            RAW'(REG_SHADOW): bus_rdata = shadow_q[addr_q];
            RAW'(REG_LOCK):   bus_rdata[NW-1:0] = lock_q;
            default:          bus_rdata = '0;
        endcase
    end

    // R6
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && !clr_hit) |=> err_q);

    // R5
    busy_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && busy) |=> err_q);

    // R7
    lock_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fuse_active && op_cur == OP_PROG) |-> !lock_q[addr_l]);

    // R8
    once_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fuse_active && op_cur == OP_PROG && ecc_l) |-> !pgmd_q[addr_l]);

    // R4
    strobe_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fuse_strobe |-> busy);

endmodule

// File: tb/sim_fuse_ctl.sv
`timescale 1ns/1ps
module sim_fuse_ctl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        fuse_strobe, fuse_active;

    int total = 0;
    int bad = 0;
    bit fin = 0;

    always #4 clk = ~clk;

    fuse_ctl u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .fuse_strobe(fuse_strobe), .fuse_active(fuse_active)
    );

    typedef struct packed {
        logic        ecc;
        logic        lk;
        logic [2:0]  a;
        logic [31:0] d;
        logic        eerr;
        logic [31:0] ew;
    } vec_t;

    localparam vec_t VT [8] = '{
        '{1'b0, 1'b0, 3'd1, 32'h0000_00F0, 1'b0, 32'h0000_00F0},
        '{1'b0, 1'b0, 3'd1, 32'h0000_0F00, 1'b0, 32'h0000_0FF0},
        '{1'b1, 1'b0, 3'd2, 32'h1234_5678, 1'b0, 32'h1234_5678},
        '{1'b1, 1'b0, 3'd2, 32'hFFFF_0000, 1'b1, 32'h1234_5678},
        '{1'b0, 1'b1, 3'd3, 32'h0000_00A5, 1'b0, 32'h0000_00A5},
        '{1'b0, 1'b0, 3'd3, 32'h0000_5A00, 1'b1, 32'h0000_00A5},
        '{1'b1, 1'b0, 3'd1, 32'h0000_0001, 1'b1, 32'h0000_0FF0},
        '{1'b0, 1'b0, 3'd7, 32'h8000_0000, 1'b0, 32'h8000_0000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        rd(3'd0, s);
        for (int g = 0; g < 2000 && s[0]; g++) begin
            @(negedge clk);
            rd(3'd0, s);
        end
    endtask

    task automatic run_cmd(input logic [31:0] c, output int nb, output int ns, output int na);
        logic [31:0] s;
        nb = 0; ns = 0; na = 0;
        wr(3'd0, c);
        rd(3'd0, s);
        for (int g = 0; g < 2000 && s[0]; g++) begin
            nb++;
            if (fuse_strobe) ns++;
            if (fuse_active) na++;
            @(negedge clk);
            rd(3'd0, s);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!fin) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int nb, ns, na;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(3'd0, v); chk("R1 ctrl", v, 32'h0);
        rd(3'd2, v); chk("R1 timing", v, 32'h0018_9042);
        rd(3'd6, v); chk("R1 shadow", v, 32'h0);
        rd(3'd7, v); chk("R1 locks", v, 32'h0);

        // R2 read timing: wait 2, relax 1, read strobe 6 -> 3+7 busy, 7 strobe, 3 active
        wr(3'd3, 32'd0);
        run_cmd(32'h1, nb, ns, na);
        chk("R2 busy", nb, 10);
        chk("R2 strobe", ns, 7);
        chk("R2 active", na, 3);
        rd(3'd5, v); chk("R12 read blank", v, 32'h0);

        // table: R7 R8 R9 R11 R12
        foreach (VT[i]) begin
            wr(3'd3, {29'd0, VT[i].a});
            wr(3'd4, VT[i].d);
            run_cmd({28'd0, VT[i].lk, VT[i].ecc, 2'b10}, nb, ns, na);
            rd(3'd0, v); chk($sformatf("R7/R8/R9 err vec%0d", i), {31'd0, v[1]}, {31'd0, VT[i].eerr});
            wr(3'd1, 32'h2);
            run_cmd(32'h1, nb, ns, na);
            rd(3'd5, v); chk($sformatf("R9/R12 word vec%0d", i), v, VT[i].ew);
        end

        // R3 program timing: relax 1, program strobe 9 -> 2+10 busy, 6 active
        wr(3'd3, 32'd4);
        wr(3'd4, 32'h33);
        run_cmd(32'h2, nb, ns, na);
        chk("R3 busy", nb, 12);
        chk("R3 strobe", ns, 10);
        chk("R3 active", na, 6);

        // R10 shadow untouched until reload
        wr(3'd3, 32'd1);
        rd(3'd6, v); chk("R10 shadow before", v, 32'h0);
        run_cmd(32'h3, nb, ns, na);
        chk("R10 reload busy", nb, 8);
        chk("R10 reload strobe", ns, 0);
        rd(3'd6, v); chk("R10 shadow w1", v, 32'h0000_0FF0);
        wr(3'd3, 32'd4);
        rd(3'd6, v); chk("R10 shadow w4", v, 32'h33);

        // R4 zero-width read pulse: read strobe 3, relax 1 -> 4-4 = 0
        wr(3'd2, 32'h000C_9042);
        run_cmd(32'h1, nb, ns, na);
        chk("R4 no busy", nb, 0);
        chk("R4 no strobe", ns, 0);
        rd(3'd0, v); chk("R4 err", v, 32'h2);
        wr(3'd2, 32'h0018_9042);
        wr(3'd1, 32'h2);

        // R5 command while busy
        wr(3'd3, 32'd5);
        wr(3'd4, 32'hDEAD_BEEF);
        wr(3'd0, 32'h1);
        wr(3'd0, 32'h2);
        rd(3'd0, v); chk("R5 err while busy", {31'd0, v[1]}, 32'h1);
        wait_idle();
        wr(3'd1, 32'h2);
        run_cmd(32'h1, nb, ns, na);
        rd(3'd5, v); chk("R5 word untouched", v, 32'h0);

        // R6 sticky error
        wr(3'd0, 32'h0000_0003 & 32'h0);
        wr(3'd3, 32'd3);
        wr(3'd0, 32'h2);
        rd(3'd0, v); chk("R6 err set", v, 32'h2);
        wr(3'd0, 32'h2 & 32'hC);
        rd(3'd0, v); chk("R6 ctrl write keeps", v, 32'h2);
        wr(3'd1, 32'h1);
        rd(3'd0, v); chk("R6 clr bit0 keeps", v, 32'h2);
        wr(3'd1, 32'h2);
        rd(3'd0, v); chk("R6 cleared", v, 32'h0);

        fin = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule